// File: doc/BRIEF.md
# Serial VID Command and Register Slave

This block sits between a serial VID bus deframer and the voltage control logic of a multi-phase regulator controller. Each cycle in which `txn_valid` is high presents one already-deframed host transaction: a 5-bit command code, one payload byte and a flag that marks a broadcast (all-call) transaction. The block decides the 2-bit response, returns register contents for reads, and issues one-cycle strobes that hand a new target VID (with its slew mode) or a new power state to the regulation logic.

The slave also owns the register file that the host reads and writes. Its entries have mixed ownership. Identity bytes are fixed at design time. Platform limits are parameters. Status, temperature zone and output-current telemetry are refreshed only by the controller. A small set of configuration entries may be written by the host. The block keeps a busy flag from an accepted VID change until the regulation logic reports that the output has settled. Power-state requests are refused while that flag is set.

Response code encoding used throughout: 00 no response (only while `rsp_valid` is low), 01 no-answer, 10 accept, 11 reject. Slew-mode encoding on `vid_slew`: 00 fast, 01 slow, 10 decay. Command codes: 01h fast SetVID, 02h slow SetVID, 03h decay SetVID, 04h set power state, 05h set register pointer, 06h write the register at the pointer, 07h read the register named by the payload. Every other code is unsupported.

Top module: `svid_cmd_slave`

## Requirements
- R1: A transaction with code 01h or 02h is answered 10 on `rsp_code` one cycle later. In that same cycle `vid_stb` is high for one cycle, `vid_target` carries the payload and `vid_slew` is 00 for 01h or 01 for 02h. Register 31h takes the payload.
- R2: Code 03h is answered 11 when the payload is greater than `vout_vid`, and nothing changes. Otherwise it is answered 10 and acts as R1 with `vid_slew` 10.
- R3: `vid_busy` goes high in the cycle after any accepted VID command. It stays high until a cycle in which `vid_settled` is high and no VID command is accepted, and is low from the following cycle. An accepted VID command in the same cycle wins over `vid_settled`.
- R4: Code 04h is answered 11 when the payload exceeds 03h or `vid_busy` is high. Otherwise it is answered 10, register 32h takes the payload and `ps_stb` pulses with `ps_value` equal to the payload, even when the value is unchanged.
- R5: Codes 05h, 06h and 07h with `txn_allcall` high are answered 01 and change nothing.
- R6: Code 05h with a known address is answered 10 and moves the pointer; register 35h reads back the pointer. An unknown address is answered 11. Known addresses: 00h, 01h, 02h, 05h, 06h, 10h, 11h, 12h, 15h, 1Ch, 21h, 22h, 24h, 25h, 30h to 35h.
- R7: Code 07h with a known address is answered 10 with the register contents on `rsp_data`. An unknown address is answered 11. `rsp_data` is 00h on every response other than an accepted read.
- R8: Code 06h writes the payload and answers 10 when the pointer holds 30h, 31h, 32h, 33h or 34h. At any other pointer it answers 11 and the addressed register keeps its value.
- R9: Registers 00h, 01h, 02h, 05h and 06h read 1Eh, 84h, 00h, 02h and 81h. Registers 21h, 22h, 24h and 25h read 7Dh, 64h, 0Ah and 02h. Register 30h resets to B5h. Registers 31h to 35h reset to 00h.
- R10: Register 15h holds `isense` as sampled one cycle earlier, unless register 32h held 03h at that sample, in which case it holds 04h.
- R11: An accepted read of register 11h copies the value returned into register 1Ch.
- R12: Codes 00h and 08h to 1Fh are answered 11. A reject or no-answer changes no register, the pointer, or any strobe.
- R13: Registers 10h, 11h and 12h hold `ctl_stat1`, `ctl_stat2` and `ctl_tzone` as sampled one cycle earlier. All of them reset to 00h, together with 15h and 1Ch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| txn_valid | input | 1 | A deframed transaction is present this cycle |
| txn_cmd | input | 5 | Command code |
| txn_payload | input | 8 | VID, power state, address or write data |
| txn_allcall | input | 1 | Transaction was broadcast to all slaves |
| vout_vid | input | 8 | VID code of the present output voltage |
| vid_settled | input | 1 | Regulation logic reports the output reached its target |
| isense | input | 8 | Sensed output-current code |
| ctl_stat1 | input | 8 | Controller-owned status byte one |
| ctl_stat2 | input | 8 | Controller-owned status byte two |
| ctl_tzone | input | 8 | Controller-owned temperature zone byte |
| rsp_valid | output | 1 | Response present |
| rsp_code | output | 2 | Response code (01 no-answer, 10 accept, 11 reject) |
| rsp_data | output | 8 | Read data for an accepted read, else 00h |
| vid_stb | output | 1 | One-cycle new-target strobe |
| vid_target | output | 8 | New target VID, 00h when no strobe |
| vid_slew | output | 2 | Slew mode (00 fast, 01 slow, 10 decay), 00 when no strobe |
| ps_stb | output | 1 | One-cycle new power-state strobe |
| ps_value | output | 8 | New power state, 00h when no strobe |
| vid_busy | output | 1 | A VID transition is in progress |

## Verification
Every response, read byte and strobe is due in the cycle after the transaction cycle. `vid_busy` and all register updates take effect from that same cycle, so a read issued the next cycle already sees them. Telemetry and status registers lag their inputs by one cycle, so a read of them returns the input value from two cycles before the response. The bench drives inputs on the falling edge. It updates a behavioural model on each rising edge and compares every output on the following falling edge, which is exactly where these latencies place each result.

// File: rtl/svid_slave_pkg.sv
package svid_slave_pkg;

   typedef enum logic [1:0] {
      RSP_IDLE = 2'b00,
      RSP_NAK  = 2'b01,
      RSP_ACK  = 2'b10,
      RSP_REJ  = 2'b11
   } rsp_e;

   typedef enum logic [1:0] {
      SLEW_FAST  = 2'b00,
      SLEW_SLOW  = 2'b01,
      SLEW_DECAY = 2'b10
   } slew_e;

   localparam logic [7:0] CMD_VID_FAST  = 8'h01;
   localparam logic [7:0] CMD_VID_SLOW  = 8'h02;
   localparam logic [7:0] CMD_VID_DECAY = 8'h03;
   localparam logic [7:0] CMD_SET_PS    = 8'h04;
   localparam logic [7:0] CMD_SET_PTR   = 8'h05;
   localparam logic [7:0] CMD_WR_DATA   = 8'h06;
   localparam logic [7:0] CMD_RD_REG    = 8'h07;

   localparam logic [7:0] A_VENDOR  = 8'h00;
   localparam logic [7:0] A_PRODUCT = 8'h01;
   localparam logic [7:0] A_REV     = 8'h02;
   localparam logic [7:0] A_PROTO   = 8'h05;
   localparam logic [7:0] A_CAPS    = 8'h06;
   localparam logic [7:0] A_STAT1   = 8'h10;
   localparam logic [7:0] A_STAT2   = 8'h11;
   localparam logic [7:0] A_TZONE   = 8'h12;
   localparam logic [7:0] A_IOUT    = 8'h15;
   localparam logic [7:0] A_S2COPY  = 8'h1C;
   localparam logic [7:0] A_ICCMAX  = 8'h21;
   localparam logic [7:0] A_TMAX    = 8'h22;
   localparam logic [7:0] A_SRFAST  = 8'h24;
   localparam logic [7:0] A_SRSLOW  = 8'h25;
   localparam logic [7:0] A_VMAX    = 8'h30;
   localparam logic [7:0] A_VIDSET  = 8'h31;
   localparam logic [7:0] A_PSTATE  = 8'h32;
   localparam logic [7:0] A_OFFSET  = 8'h33;
   localparam logic [7:0] A_MVCFG   = 8'h34;
   localparam logic [7:0] A_PTRCOPY = 8'h35;

   function automatic logic addr_known(input logic [7:0] a);
      case (a)
         A_VENDOR, A_PRODUCT, A_REV, A_PROTO, A_CAPS,
         A_STAT1, A_STAT2, A_TZONE, A_IOUT, A_S2COPY,
         A_ICCMAX, A_TMAX, A_SRFAST, A_SRSLOW,
         A_VMAX, A_VIDSET, A_PSTATE, A_OFFSET, A_MVCFG, A_PTRCOPY: return 1'b1;
         default: return 1'b0;
      endcase
   endfunction

   function automatic logic addr_host_rw(input logic [7:0] a);
      case (a)
         A_VMAX, A_VIDSET, A_PSTATE, A_OFFSET, A_MVCFG: return 1'b1;
         default: return 1'b0;
      endcase
   endfunction

   typedef struct packed {
      rsp_e  rsp;
      logic  vid_go;
      slew_e slew;
      logic  ps_go;
      logic  ptr_go;
      logic  wr_go;
      logic  rd_go;
   } act_t;

endpackage

// File: rtl/svid_cmd_decode.sv
module svid_cmd_decode
   import svid_slave_pkg::*;
#(
   parameter int DW     = 8,
   parameter int CMD_W  = 5,
   parameter int PS_MAX = 3
) (
   input  logic             txn_valid,
   input  logic [CMD_W-1:0] txn_cmd,
   input  logic [DW-1:0]    txn_payload,
   input  logic             txn_allcall,
   input  logic [DW-1:0]    vout_vid,
   input  logic             busy,
   input  logic [DW-1:0]    ptr,
   output act_t             act
);

   localparam logic [DW-1:0] PS_LIMIT = DW'(PS_MAX);

   logic [7:0] cmd8;
   assign cmd8 = 8'(txn_cmd);

   always_comb begin
      act      = '0;
      act.rsp  = RSP_IDLE;
      act.slew = SLEW_FAST;
      if (txn_valid) begin
         act.rsp = RSP_REJ;
         case (cmd8)
            CMD_VID_FAST, CMD_VID_SLOW: begin
               act.rsp    = RSP_ACK;
               act.vid_go = 1'b1;
               act.slew   = (cmd8 == CMD_VID_FAST) ? SLEW_FAST : SLEW_SLOW;
            end
            CMD_VID_DECAY: begin
               if (txn_payload <= vout_vid) begin
                  act.rsp    = RSP_ACK;
                  act.vid_go = 1'b1;
                  act.slew   = SLEW_DECAY;
               end
            end
            CMD_SET_PS: begin
               if (txn_payload <= PS_LIMIT && !busy) begin
                  act.rsp   = RSP_ACK;
                  act.ps_go = 1'b1;
               end
            end
            CMD_SET_PTR: begin
               if (txn_allcall) act.rsp = RSP_NAK;
               else if (addr_known(txn_payload[7:0])) begin
                  act.rsp    = RSP_ACK;
                  act.ptr_go = 1'b1;
               end
            end
            CMD_WR_DATA: begin
               if (txn_allcall) act.rsp = RSP_NAK;
               else if (addr_host_rw(ptr[7:0])) begin
                  act.rsp   = RSP_ACK;
                  act.wr_go = 1'b1;
               end
            end
            CMD_RD_REG: begin
               if (txn_allcall) act.rsp = RSP_NAK;
               else if (addr_known(txn_payload[7:0])) begin
                  act.rsp   = RSP_ACK;
                  act.rd_go = 1'b1;
               end
            end
            default: act.rsp = RSP_REJ;
         endcase
      end
   end

   // R12: unsupported codes never produce an accept
   always_comb begin
      if (txn_valid && (cmd8 == 8'h00 || cmd8 >= 8'h08))
         assert_unsup_rej_R12: assert (act.rsp == RSP_REJ && !act.vid_go && !act.ps_go);
   end

endmodule

// File: rtl/svid_reg_file.sv
module svid_reg_file
   import svid_slave_pkg::*;
#(
   parameter int          DW           = 8,
   parameter logic [7:0]  VENDOR_ID    = 8'h1E,
   parameter logic [7:0]  PRODUCT_ID   = 8'h84,
   parameter logic [7:0]  REVISION     = 8'h00,
   parameter logic [7:0]  PROTOCOL     = 8'h02,
   parameter logic [7:0]  CAPABILITY   = 8'h81,
   parameter logic [7:0]  ICC_MAX      = 8'h7D,
   parameter logic [7:0]  TEMP_MAX     = 8'h64,
   parameter logic [7:0]  SR_FAST      = 8'h0A,
   parameter logic [7:0]  SR_SLOW      = 8'h02,
   parameter logic [7:0]  VOUT_MAX_RST = 8'hB5,
   parameter logic [7:0]  PS_IOUT_FIX  = 8'h03,
   parameter logic [7:0]  IOUT_FIXED   = 8'h04
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [DW-1:0] wdata,
   input  logic          vid_wr,
   input  logic          ps_wr,
   input  logic          ptr_wr,
   input  logic          dat_wr,
   input  logic          rd_en,
   input  logic [DW-1:0] rd_addr,
   input  logic [DW-1:0] isense_i,
   input  logic [DW-1:0] st1_i,
   input  logic [DW-1:0] st2_i,
   input  logic [DW-1:0] tz_i,
   output logic [DW-1:0] rd_data,
   output logic [DW-1:0] ptr_o
);

   logic [DW-1:0] ptr_q, vidset_q, pstate_q, offset_q, vmax_q, mvcfg_q;
   logic [DW-1:0] st1_q, st2_q, tz_q, iout_q, s2copy_q;
   logic [DW-1:0] rd_mux;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr_q    <= '0;
         vidset_q <= '0;
         pstate_q <= '0;
         offset_q <= '0;
         vmax_q   <= VOUT_MAX_RST;
         mvcfg_q  <= '0;
         st1_q    <= '0;
         st2_q    <= '0;
         tz_q     <= '0;
         iout_q   <= '0;
         s2copy_q <= '0;
      end else begin
         if (ptr_wr) ptr_q <= wdata;
         if (vid_wr || (dat_wr && ptr_q == A_VIDSET)) vidset_q <= wdata;
         if (ps_wr  || (dat_wr && ptr_q == A_PSTATE)) pstate_q <= wdata;
         if (dat_wr && ptr_q == A_OFFSET) offset_q <= wdata;
         if (dat_wr && ptr_q == A_VMAX)   vmax_q   <= wdata;
         if (dat_wr && ptr_q == A_MVCFG)  mvcfg_q  <= wdata;
         st1_q  <= st1_i;
         st2_q  <= st2_i;
         tz_q   <= tz_i;
         iout_q <= (pstate_q == PS_IOUT_FIX) ? IOUT_FIXED : isense_i;
         if (rd_en && rd_addr == A_STAT2) s2copy_q <= st2_q;
      end
   end

   always_comb begin
      case (rd_addr)
         A_VENDOR:  rd_mux = VENDOR_ID;
         A_PRODUCT: rd_mux = PRODUCT_ID;
         A_REV:     rd_mux = REVISION;
         A_PROTO:   rd_mux = PROTOCOL;
         A_CAPS:    rd_mux = CAPABILITY;
         A_STAT1:   rd_mux = st1_q;
         A_STAT2:   rd_mux = st2_q;
         A_TZONE:   rd_mux = tz_q;
         A_IOUT:    rd_mux = iout_q;
         A_S2COPY:  rd_mux = s2copy_q;
         A_ICCMAX:  rd_mux = ICC_MAX;
         A_TMAX:    rd_mux = TEMP_MAX;
         A_SRFAST:  rd_mux = SR_FAST;
         A_SRSLOW:  rd_mux = SR_SLOW;
         A_VMAX:    rd_mux = vmax_q;
         A_VIDSET:  rd_mux = vidset_q;
         A_PSTATE:  rd_mux = pstate_q;
         A_OFFSET:  rd_mux = offset_q;
         A_MVCFG:   rd_mux = mvcfg_q;
         A_PTRCOPY: rd_mux = ptr_q;
         default:   rd_mux = '0;
      endcase
   end

   assign rd_data = rd_en ? rd_mux : '0;
   assign ptr_o   = ptr_q;

   assert_iout_fixed_R10: assert property (@(posedge clk) disable iff (!rst_n)
      pstate_q == PS_IOUT_FIX |=> iout_q == IOUT_FIXED);

   assert_s2_copy_R11: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en && rd_addr == A_STAT2 |=> s2copy_q == $past(st2_q));

   assert_vidset_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !vid_wr && !dat_wr |=> $stable(vidset_q));

endmodule

// File: rtl/svid_vid_tracker.sv
module svid_vid_tracker (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic settled_i,
   output logic busy_o
);

   logic busy_q;

   always_ff @(posedge clk) begin
      if (!rst_n)         busy_q <= 1'b0;
      else if (set_i)     busy_q <= 1'b1;
      else if (settled_i) busy_q <= 1'b0;
   end

   assign busy_o = busy_q;

   assert_busy_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> busy_q);

   assert_busy_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
      settled_i && !set_i |=> !busy_q);

endmodule

// File: rtl/svid_cmd_slave.sv
module svid_cmd_slave
   import svid_slave_pkg::*;
#(
   parameter int          DW           = 8,
   parameter int          CMD_W        = 5,
   parameter int          PS_MAX       = 3,
   parameter bit          RSP_PIPE     = 1'b1,
   parameter logic [7:0]  VENDOR_ID    = 8'h1E,
   parameter logic [7:0]  PRODUCT_ID   = 8'h84,
   parameter logic [7:0]  REVISION     = 8'h00,
   parameter logic [7:0]  PROTOCOL     = 8'h02,
   parameter logic [7:0]  CAPABILITY   = 8'h81,
   parameter logic [7:0]  ICC_MAX      = 8'h7D,
   parameter logic [7:0]  TEMP_MAX     = 8'h64,
   parameter logic [7:0]  SR_FAST      = 8'h0A,
   parameter logic [7:0]  SR_SLOW      = 8'h02,
   parameter logic [7:0]  VOUT_MAX_RST = 8'hB5,
   parameter logic [7:0]  PS_IOUT_FIX  = 8'h03,
   parameter logic [7:0]  IOUT_FIXED   = 8'h04
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             txn_valid,
   input  logic [CMD_W-1:0] txn_cmd,
   input  logic [DW-1:0]    txn_payload,
   input  logic             txn_allcall,
   input  logic [DW-1:0]    vout_vid,
   input  logic             vid_settled,
   input  logic [DW-1:0]    isense,
   input  logic [DW-1:0]    ctl_stat1,
   input  logic [DW-1:0]    ctl_stat2,
   input  logic [DW-1:0]    ctl_tzone,
   output logic             rsp_valid,
   output logic [1:0]       rsp_code,
   output logic [DW-1:0]    rsp_data,
   output logic             vid_stb,
   output logic [DW-1:0]    vid_target,
   output logic [1:0]       vid_slew,
   output logic             ps_stb,
   output logic [DW-1:0]    ps_value,
   output logic             vid_busy
);

   if (DW != 8) begin : g_bad_dw
      $error("svid_cmd_slave: DW must be 8 (register bytes)");
   end
   if (CMD_W < 3 || CMD_W > 8) begin : g_bad_cmd
      $error("svid_cmd_slave: CMD_W must lie in 3..8");
   end
   if (PS_MAX < 0 || PS_MAX > 255) begin : g_bad_ps
      $error("svid_cmd_slave: PS_MAX must fit a byte");
   end

   act_t          act;
   logic          busy;
   logic [DW-1:0] ptr;
   logic [DW-1:0] rd_data;

   svid_cmd_decode #(.DW(DW), .CMD_W(CMD_W), .PS_MAX(PS_MAX)) u_dec (
      .txn_valid  (txn_valid),
      .txn_cmd    (txn_cmd),
      .txn_payload(txn_payload),
      .txn_allcall(txn_allcall),
      .vout_vid   (vout_vid),
      .busy       (busy),
      .ptr        (ptr),
      .act        (act)
   );

   svid_reg_file #(
      .DW(DW), .VENDOR_ID(VENDOR_ID), .PRODUCT_ID(PRODUCT_ID),
      .REVISION(REVISION), .PROTOCOL(PROTOCOL), .CAPABILITY(CAPABILITY),
      .ICC_MAX(ICC_MAX), .TEMP_MAX(TEMP_MAX), .SR_FAST(SR_FAST),
      .SR_SLOW(SR_SLOW), .VOUT_MAX_RST(VOUT_MAX_RST),
      .PS_IOUT_FIX(PS_IOUT_FIX), .IOUT_FIXED(IOUT_FIXED)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wdata   (txn_payload),
      .vid_wr  (act.vid_go),
      .ps_wr   (act.ps_go),
      .ptr_wr  (act.ptr_go),
      .dat_wr  (act.wr_go),
      .rd_en   (act.rd_go),
      .rd_addr (txn_payload),
      .isense_i(isense),
      .st1_i   (ctl_stat1),
      .st2_i   (ctl_stat2),
      .tz_i    (ctl_tzone),
      .rd_data (rd_data),
      .ptr_o   (ptr)
   );

   svid_vid_tracker u_trk (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_i    (act.vid_go),
      .settled_i(vid_settled),
      .busy_o   (busy)
   );

   assign vid_busy = busy;

   if (RSP_PIPE) begin : g_pipe
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_code   <= RSP_IDLE;
            rsp_data   <= '0;
            vid_stb    <= 1'b0;
            vid_target <= '0;
            vid_slew   <= SLEW_FAST;
            ps_stb     <= 1'b0;
            ps_value   <= '0;
         end else begin
            rsp_valid  <= txn_valid;
            rsp_code   <= act.rsp;
            rsp_data   <= rd_data;
            vid_stb    <= act.vid_go;
            vid_target <= act.vid_go ? txn_payload : '0;
            vid_slew   <= act.vid_go ? act.slew : SLEW_FAST;
            ps_stb     <= act.ps_go;
            ps_value   <= act.ps_go ? txn_payload : '0;
         end
      end

      assert_allcall_nak_R5: assert property (@(posedge clk) disable iff (!rst_n)
         txn_valid && txn_allcall && act.rd_go == 1'b0 &&
         (8'(txn_cmd) >= CMD_SET_PTR && 8'(txn_cmd) <= CMD_RD_REG)
         |=> rsp_code == RSP_NAK && rsp_data == '0);

      assert_vid_ack_R1: assert property (@(posedge clk) disable iff (!rst_n)
         vid_stb |-> rsp_valid && rsp_code == RSP_ACK && vid_busy);

      assert_ps_busy_rej_R4: assert property (@(posedge clk) disable iff (!rst_n)
         txn_valid && 8'(txn_cmd) == CMD_SET_PS && vid_busy |=> rsp_code == RSP_REJ && !ps_stb);
   end else begin : g_comb
      always_comb begin
         rsp_valid  = txn_valid;
         rsp_code   = act.rsp;
         rsp_data   = rd_data;
         vid_stb    = act.vid_go;
         vid_target = act.vid_go ? txn_payload : '0;
         vid_slew   = act.vid_go ? act.slew : SLEW_FAST;
         ps_stb     = act.ps_go;
         ps_value   = act.ps_go ? txn_payload : '0;
      end
   end

   assert_ptr_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      txn_valid && act.rsp != RSP_ACK |=> $stable(ptr));

   assert_strobe_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({vid_stb, ps_stb}));

endmodule

// File: tb/sim_svid_cmd_slave.sv
`timescale 1ns/1ps
module sim_svid_cmd_slave;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       txn_valid = 1'b0;
   logic [4:0] txn_cmd = '0;
   logic [7:0] txn_payload = '0;
   logic       txn_allcall = 1'b0;
   logic [7:0] vout_vid = '0;
   logic       vid_settled = 1'b0;
   logic [7:0] isense = '0, ctl_stat1 = '0, ctl_stat2 = '0, ctl_tzone = '0;
   logic       rsp_valid, vid_stb, ps_stb, vid_busy;
   logic [1:0] rsp_code, vid_slew;
   logic [7:0] rsp_data, vid_target, ps_value;

   always #10 clk = ~clk;

   svid_cmd_slave u0 (
      .clk(clk), .rst_n(rst_n), .txn_valid(txn_valid), .txn_cmd(txn_cmd),
      .txn_payload(txn_payload), .txn_allcall(txn_allcall), .vout_vid(vout_vid),
      .vid_settled(vid_settled), .isense(isense), .ctl_stat1(ctl_stat1),
      .ctl_stat2(ctl_stat2), .ctl_tzone(ctl_tzone), .rsp_valid(rsp_valid),
      .rsp_code(rsp_code), .rsp_data(rsp_data), .vid_stb(vid_stb),
      .vid_target(vid_target), .vid_slew(vid_slew), .ps_stb(ps_stb),
      .ps_value(ps_value), .vid_busy(vid_busy)
   );

   int checks = 0;
   int errors = 0;

   // behavioural model state
   int m_ptr, m_vid, m_ps, m_off, m_vmax, m_mvc, m_s1, m_s2, m_tz, m_iout, m_s2c;
   bit m_busy;
   bit e_valid, e_vstb, e_pstb, e_busy;
   int e_code, e_data, e_vt, e_vs, e_pv;
   string e_tag = "R13";

   function automatic bit known(int a);
      int list[20] = '{'h00,'h01,'h02,'h05,'h06,'h10,'h11,'h12,'h15,'h1C,
                       'h21,'h22,'h24,'h25,'h30,'h31,'h32,'h33,'h34,'h35};
      foreach (list[i]) if (list[i] == a) return 1'b1;
      return 1'b0;
   endfunction

   function automatic bit host_rw(int a);
      return (a >= 'h30 && a <= 'h34);
   endfunction

   function automatic int model_read(int a);
      case (a)
         'h00: return 'h1E;  'h01: return 'h84;  'h02: return 'h00;
         'h05: return 'h02;  'h06: return 'h81;  'h10: return m_s1;
         'h11: return m_s2;  'h12: return m_tz;  'h15: return m_iout;
         'h1C: return m_s2c; 'h21: return 'h7D;  'h22: return 'h64;
         'h24: return 'h0A;  'h25: return 'h02;  'h30: return m_vmax;
         'h31: return m_vid; 'h32: return m_ps;  'h33: return m_off;
         'h34: return m_mvc; 'h35: return m_ptr;
         default: return 0;
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ptr = 0; m_vid = 0; m_ps = 0; m_off = 0; m_vmax = 'hB5; m_mvc = 0;
         m_s1 = 0; m_s2 = 0; m_tz = 0; m_iout = 0; m_s2c = 0; m_busy = 0;
         e_valid = 0; e_vstb = 0; e_pstb = 0; e_busy = 0;
         e_code = 0; e_data = 0; e_vt = 0; e_vs = 0; e_pv = 0; e_tag = "R13";
      end else begin
         int c, p, old_ps, old_s2, wr_ptr;
         bit rd11, wr;
         c = txn_cmd; p = txn_payload;
         old_ps = m_ps; old_s2 = m_s2; rd11 = 0; wr = 0; wr_ptr = m_ptr;
         e_valid = txn_valid; e_code = 0; e_data = 0;
         e_vstb = 0; e_vt = 0; e_vs = 0; e_pstb = 0; e_pv = 0; e_tag = "R3";
         if (txn_valid) begin
            if (c == 1 || c == 2) begin
               e_tag = "R1"; e_code = 2; e_vstb = 1; e_vt = p; e_vs = (c == 1) ? 0 : 1;
            end else if (c == 3) begin
               e_tag = "R2";
               if (p > vout_vid) e_code = 3;
               else begin e_code = 2; e_vstb = 1; e_vt = p; e_vs = 2; end
            end else if (c == 4) begin
               e_tag = "R4";
               if (p > 3 || m_busy) e_code = 3;
               else begin e_code = 2; e_pstb = 1; e_pv = p; end
            end else if (c >= 5 && c <= 7 && txn_allcall) begin
               e_tag = "R5"; e_code = 1;
            end else if (c == 5) begin
               e_tag = "R6";
               if (known(p)) begin e_code = 2; m_ptr = p; end else e_code = 3;
            end else if (c == 6) begin
               e_tag = "R8";
               if (host_rw(m_ptr)) begin e_code = 2; wr = 1; end else e_code = 3;
            end else if (c == 7) begin
               case (p)
                  'h15: e_tag = "R10";
                  'h11, 'h1C: e_tag = "R11";
                  'h10, 'h12: e_tag = "R13";
                  'h00, 'h01, 'h02, 'h05, 'h06, 'h21, 'h22, 'h24, 'h25: e_tag = "R9";
                  default: e_tag = "R7";
               endcase
               if (known(p)) begin
                  e_code = 2; e_data = model_read(p); rd11 = (p == 'h11);
               end else e_code = 3;
            end else begin
               e_tag = "R12"; e_code = 3;
            end
         end
         if (e_vstb) m_vid = e_vt;
         if (e_pstb) m_ps = e_pv;
         if (wr) begin
            case (wr_ptr)
               'h30: m_vmax = p; 'h31: m_vid = p; 'h32: m_ps = p;
               'h33: m_off = p; default: m_mvc = p;
            endcase
         end
         if (e_vstb) m_busy = 1; else if (vid_settled) m_busy = 0;
         e_busy = m_busy;
         m_iout = (old_ps == 3) ? 4 : isense;
         if (rd11) m_s2c = old_s2;
         m_s1 = ctl_stat1; m_s2 = ctl_stat2; m_tz = ctl_tzone;
      end
   end

   task automatic chk(string tag, string what, int act, int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   // per-cycle comparison against the model, away from the rising edge
   always @(negedge clk) begin
      if (rst_n) begin
         checks++;
         if (rsp_valid !== e_valid || rsp_code !== 2'(e_code) || rsp_data !== 8'(e_data) ||
             vid_stb !== e_vstb || vid_target !== 8'(e_vt) || vid_slew !== 2'(e_vs) ||
             ps_stb !== e_pstb || ps_value !== 8'(e_pv) || vid_busy !== e_busy) begin
            errors++;
            $display("FAIL %s cycle: actual v%0b c%0h d%0h vs%0b vt%0h sl%0h ps%0b pv%0h b%0b expected v%0b c%0h d%0h vs%0b vt%0h sl%0h ps%0b pv%0h b%0b",
                     e_tag, rsp_valid, rsp_code, rsp_data, vid_stb, vid_target, vid_slew,
                     ps_stb, ps_value, vid_busy, e_valid, e_code, e_data, e_vstb, e_vt,
                     e_vs, e_pstb, e_pv, e_busy);
         end
      end
   end

   task automatic send(int c, int p, bit ac);
      @(negedge clk);
      txn_valid = 1'b1; txn_cmd = 5'(c); txn_payload = 8'(p); txn_allcall = ac;
      @(negedge clk);
      txn_valid = 1'b0; txn_allcall = 1'b0;
   endtask

   // read and check a register directly at the port, one cycle after the request
   task automatic rd_expect(string tag, int a, int code, int data);
      send(7, a, 1'b0);
      chk(tag, "rsp_code", rsp_code, code);
      chk(tag, "rsp_data", rsp_data, data);
   endtask

   task automatic settle();
      @(negedge clk); vid_settled = 1'b1;
      @(negedge clk); vid_settled = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R13", "reset rsp_valid", rsp_valid, 0);
      chk("R3", "reset vid_busy", vid_busy, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R9 identity and platform bytes, reset values
      rd_expect("R9", 'h00, 2, 'h1E);
      rd_expect("R9", 'h01, 2, 'h84);
      rd_expect("R9", 'h06, 2, 'h81);
      rd_expect("R9", 'h21, 2, 'h7D);
      rd_expect("R9", 'h30, 2, 'hB5);
      rd_expect("R7", 'h99, 3, 0);

      // R1 fast SetVID, R3 busy, R4 power state refused while busy
      send(1, 'h40, 1'b0);
      chk("R1", "vid_target", vid_target, 'h40);
      chk("R3", "vid_busy", vid_busy, 1);
      send(4, 2, 1'b0);
      chk("R4", "busy reject", rsp_code, 3);
      settle();
      chk("R3", "busy cleared", vid_busy, 0);
      send(4, 2, 1'b0);
      chk("R4", "ps accept", ps_value, 2);
      send(4, 2, 1'b0);
      chk("R4", "ps same accept", rsp_code, 2);
      send(4, 5, 1'b0);
      chk("R4", "ps range reject", rsp_code, 3);
      rd_expect("R1", 'h31, 2, 'h40);

      // R2 decay against present output
      vout_vid = 'h50;
      send(3, 'h60, 1'b0);
      chk("R2", "decay up reject", rsp_code, 3);
      rd_expect("R2", 'h31, 2, 'h40);
      send(3, 'h50, 1'b0);
      chk("R2", "decay equal slew", vid_slew, 2);
      send(2, 'h30, 1'b0);
      chk("R1", "slow slew", vid_slew, 1);
      settle();

      // R5 all-call
      send(5, 'h33, 1'b1);
      chk("R5", "allcall ptr", rsp_code, 1);
      send(7, 'h00, 1'b1);
      chk("R5", "allcall read data", rsp_data, 0);
      rd_expect("R6", 'h35, 2, 0);

      // R6 / R8 pointer and writes
      send(5, 'h33, 1'b0);
      send(6, 'h12, 1'b0);
      chk("R8", "write offset", rsp_code, 2);
      rd_expect("R8", 'h33, 2, 'h12);
      send(5, 'h01, 1'b0);
      send(6, 'h55, 1'b0);
      chk("R8", "ro write reject", rsp_code, 3);
      rd_expect("R8", 'h01, 2, 'h84);
      send(5, 'h40, 1'b0);
      chk("R6", "bad ptr", rsp_code, 3);
      rd_expect("R6", 'h35, 2, 'h01);

      // R10 telemetry, R11 copy, R13 status
      isense = 'h37; ctl_stat2 = 'hA5; ctl_stat1 = 'h3C; ctl_tzone = 'h07;
      repeat (2) @(negedge clk);
      rd_expect("R10", 'h15, 2, 'h37);
      rd_expect("R13", 'h10, 2, 'h3C);
      rd_expect("R11", 'h1C, 2, 0);
      rd_expect("R11", 'h11, 2, 'hA5);
      rd_expect("R11", 'h1C, 2, 'hA5);
      send(4, 3, 1'b0);
      repeat (2) @(negedge clk);
      rd_expect("R10", 'h15, 2, 'h04);

      // R12 unsupported codes
      send(0, 0, 1'b0);
      chk("R12", "code 00", rsp_code, 3);
      send('h08, 0, 1'b0);
      chk("R12", "code 08", rsp_code, 3);
      send('h1F, 0, 1'b0);
      chk("R12", "code 1F", rsp_code, 3);

      // R3 set wins over settled in the same cycle
      @(negedge clk);
      txn_valid = 1; txn_cmd = 1; txn_payload = 'h22; vid_settled = 1;
      @(negedge clk);
      txn_valid = 0; vid_settled = 0;
      chk("R3", "set wins", vid_busy, 1);
      settle();

      // mixed traffic compared against the model every cycle
      for (int n = 0; n < 400; n++) begin
         @(negedge clk);
         txn_valid   = ($urandom_range(0, 3) != 0);
         txn_cmd     = 5'($urandom_range(0, 9));
         txn_payload = ($urandom_range(0, 1) != 0) ? 8'($urandom_range(0, 'h36)) : 8'($urandom_range(0, 5));
         txn_allcall = ($urandom_range(0, 5) == 0);
         vid_settled = ($urandom_range(0, 3) == 0);
         vout_vid    = 8'($urandom);
         isense      = 8'($urandom);
         ctl_stat1   = 8'($urandom);
         ctl_stat2   = 8'($urandom);
         ctl_tzone   = 8'($urandom);
      end
      @(negedge clk);
      txn_valid = 0; vid_settled = 0;
      repeat (3) @(negedge clk);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule